// File: doc/BRIEF.md
# Front-End Power-Up and Safe-Mode Sequencer

This controller brings a radar front end up in a fixed order after reset. It first holds the processing logic in reset for a fixed number of millisecond ticks. Only after that reset is released may the power-amplifier drain supply come up, and only after the supply has settled does the transmit mixer get enabled, so no chirp can leave before the amplifier path is stable. A board strap says whether the amplifier path is fitted. When it is not, the reset pulse still runs in full and only the amplifier step is skipped.

A fault monitor runs alongside the sequence. It counts fault strobes and also takes a direct emergency request. Either source latches a sticky emergency flag that forces the sequencer into a safe state. The safe state cuts the amplifier supply and the mixer, keeps the processing logic out of reset, and blinks an indicator. Only a reset leaves it.

States: `ST_RST_HOLD` (processing logic in reset), `ST_PA_RAMP` (supply on, mixer off), `ST_RUN_PA` (supply and mixer on), `ST_RUN_RXONLY` (mixer on, no supply), `ST_SAFE` (latched shutdown). Transitions:
- HOLD→RAMP when the hold timer expires with the strap high.
- HOLD→RXONLY when the hold timer expires with the strap low.
- RAMP→RUN_PA when the settle timer expires.
- Any state→SAFE on a trip.
- SAFE→SAFE until reset.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `fpga_rst_n`, `pa_vdd_en`, `tx_mix_en` and `safe_led` are all 0.
- R2: `fpga_rst_n` stays 0 until RST_MS rising-edge samples of `ms_tick` have been taken. It goes to 1 at the clock edge that samples the RST_MS-th tick.
- R3: `pa_vdd_en` is never 1 while `fpga_rst_n` is 0. With `pa_present` high at the edge that releases reset, `pa_vdd_en` rises on that same edge.
- R4: With `pa_present` low, the reset hold still lasts RST_MS ticks, `pa_vdd_en` stays 0, and `tx_mix_en` rises on the edge that releases reset.
- R5: With the amplifier path present, `tx_mix_en` rises on the edge that samples the PA_SETTLE_MS-th tick after `pa_vdd_en` rose. It never rises on the same edge as `pa_vdd_en`. Both then stay 1.
- R6: An `emerg_req` high at a clock edge enters safe mode at that edge. From that edge, `pa_vdd_en` and `tx_mix_en` are 0 and `fpga_rst_n` is 1.
- R7: Each edge with `fault_strobe` high adds one to an internal fault count. The count saturates at ERR_LIMIT+1. The edge whose strobe makes the count exceed ERR_LIMIT enters safe mode.
- R8: Safe mode holds until reset, whatever the inputs do, including further fault strobes and emergency requests.
- R9: `safe_led` is 0 outside safe mode. It is 1 on the entry edge and inverts on every BLINK_HALF_MS-th tick sampled after entry.
- R10: A trip during the reset hold goes straight to safe mode, so `pa_vdd_en` never rises. A later reset restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| pa_present | input | 1 | Strap: amplifier path fitted |
| fault_strobe | input | 1 | One count per cycle high |
| emerg_req | input | 1 | Direct emergency request |
| fpga_rst_n | output | 1 | Processing-logic reset, active low |
| pa_vdd_en | output | 1 | Amplifier drain supply enable |
| tx_mix_en | output | 1 | Transmit mixer enable |
| safe_led | output | 1 | Blinking safe-mode indicator |

## Verification
The hardest situation to reach is a count-driven trip that lands inside the reset hold, before any amplifier step. The bench resets with the strap high and, a few cycles into the hold, holds `fault_strobe` high for eleven consecutive cycles. This crosses the limit long before the hold timer could expire, so any path that brings up the supply before honouring the trip shows up. A behavioural model tracks phase, tick counts, the fault count and the blink phase. It is compared on every cycle through bring-up, run, emergency entry, saturation and blinking.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [2:0] {
        ST_RST_HOLD   = 3'd0,
        ST_PA_RAMP    = 3'd1,
        ST_RUN_PA     = 3'd2,
        ST_RUN_RXONLY = 3'd3,
        ST_SAFE       = 3'd4
    } seq_state_t;
endpackage

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
    parameter int MAX_MS = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ms_tick,
    input  logic                        en,
    input  logic                        clr,
    input  logic [$clog2(MAX_MS+1)-1:0] limit,
    output logic                        done
);
    localparam int TW = $clog2(MAX_MS + 1);

    logic [TW-1:0] cnt_q;

    assign done = en && ms_tick && (cnt_q == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !en) begin
            cnt_q <= '0;
        end else if (ms_tick) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // R2: the count never runs past the programmed limit while enabled
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < limit));
endmodule

// File: rtl/pwrseq_fault_latch.sv
module pwrseq_fault_latch #(
    parameter int ERR_LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_strobe,
    input  logic emerg_req,
    output logic tripped
);
    localparam int CW  = $clog2(ERR_LIMIT + 2);
    localparam int SAT = ERR_LIMIT + 1;

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          flag_q, set_now;

    always_comb begin
        cnt_nxt = cnt_q;
        if (fault_strobe && (int'(cnt_q) != SAT)) begin
            cnt_nxt = cnt_q + CW'(1);
        end
        set_now = emerg_req || (int'(cnt_nxt) > ERR_LIMIT);
    end

    assign tripped = flag_q || set_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            flag_q <= flag_q || set_now;
        end
    end

    // R7: the counter stops at the saturation value
    a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= SAT);
    // R7: a count beyond the limit always has the flag set
    a_r7_over_limit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) > ERR_LIMIT) |-> flag_q);
    // R8: the emergency flag is sticky
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);
endmodule

// File: rtl/pwrseq_blinker.sv
module pwrseq_blinker #(
    parameter int BLINK_HALF_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic run,
    output logic phase
);
    localparam int BW = $clog2(BLINK_HALF_MS + 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (ms_tick) begin
            if (int'(cnt_q) == BLINK_HALF_MS - 1) begin
                cnt_q <= '0;
                phase <= ~phase;
            end else begin
                cnt_q <= cnt_q + BW'(1);
            end
        end
    end

    // R9: while running, the phase only changes after a sampled tick
    a_r9_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(phase)) |-> $past(ms_tick));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int RST_MS        = 10,
    parameter int PA_SETTLE_MS  = 5,
    parameter int ERR_LIMIT     = 10,
    parameter int BLINK_HALF_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic pa_present,
    input  logic fault_strobe,
    input  logic emerg_req,
    output logic fpga_rst_n,
    output logic pa_vdd_en,
    output logic tx_mix_en,
    output logic safe_led
);
    localparam int MAX_MS = (RST_MS > PA_SETTLE_MS) ? RST_MS : PA_SETTLE_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    seq_state_t    state_q, state_nxt;
    logic          tripped, tmr_done, tmr_en, tmr_clr, blink_phase;
    logic [TW-1:0] tmr_limit;

    pwrseq_fault_latch #(.ERR_LIMIT(ERR_LIMIT)) u_fault (
        .clk(clk), .rst_n(rst_n), .fault_strobe(fault_strobe),
        .emerg_req(emerg_req), .tripped(tripped)
    );

    assign tmr_en    = (state_q == ST_RST_HOLD) || (state_q == ST_PA_RAMP);
    assign tmr_limit = (state_q == ST_RST_HOLD) ? TW'(RST_MS) : TW'(PA_SETTLE_MS);
    assign tmr_clr   = (state_nxt != state_q);

    pwrseq_ms_timer #(.MAX_MS(MAX_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .en(tmr_en),
        .clr(tmr_clr), .limit(tmr_limit), .done(tmr_done)
    );

    pwrseq_blinker #(.BLINK_HALF_MS(BLINK_HALF_MS)) u_blink (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .run(state_q == ST_SAFE), .phase(blink_phase)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RST_HOLD:   if (tmr_done) state_nxt = pa_present ? ST_PA_RAMP : ST_RUN_RXONLY;
            ST_PA_RAMP:    if (tmr_done) state_nxt = ST_RUN_PA;
            ST_RUN_PA:     state_nxt = ST_RUN_PA;
            ST_RUN_RXONLY: state_nxt = ST_RUN_RXONLY;
            ST_SAFE:       state_nxt = ST_SAFE;
            default:       state_nxt = ST_SAFE;
        endcase
        if (tripped) state_nxt = ST_SAFE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_HOLD;
        else        state_q <= state_nxt;
    end

    // Output decode
    always_comb begin
        fpga_rst_n = 1'b1;
        pa_vdd_en  = 1'b0;
        tx_mix_en  = 1'b0;
        safe_led   = 1'b0;
        unique case (state_q)
            ST_RST_HOLD:   fpga_rst_n = 1'b0;
            ST_PA_RAMP:    pa_vdd_en  = 1'b1;
            ST_RUN_PA:     begin pa_vdd_en = 1'b1; tx_mix_en = 1'b1; end
            ST_RUN_RXONLY: tx_mix_en  = 1'b1;
            ST_SAFE:       safe_led   = blink_phase;
            default:       fpga_rst_n = 1'b0;
        endcase
    end

    // R3: supply only with the processing logic out of reset
    a_r3_pa_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        pa_vdd_en |-> fpga_rst_n);
    // R5: mixer is never switched on together with the supply
    a_r5_mix_not_with_pa: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pa_vdd_en) |-> !tx_mix_en);
    // R6: a trip leaves supply and mixer off from the next edge
    a_r6_trip_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> (!pa_vdd_en && !tx_mix_en && fpga_rst_n));
    // R8: safe state is left only through reset
    a_r8_safe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAFE) |=> (state_q == ST_SAFE));
endmodule

// File: tb/pwrseq_ctrl_test.sv
module pwrseq_ctrl_test;
    localparam int RST_MS = 10, SETTLE = 5, ELIM = 10, BH = 4, TICKDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ms_tick = 1'b0, pa_strap = 1'b1, flt = 1'b0, emg = 1'b0;
    logic fpga_rst_n, pa_vdd_en, tx_mix_en, safe_led;
    int   nchk = 0, nerr = 0, cyc = 0;
    bit   finished = 1'b0;
    string phase = "R1 reset";

    always #4 clk = ~clk;

    pwrseq_ctrl #(.RST_MS(RST_MS), .PA_SETTLE_MS(SETTLE), .ERR_LIMIT(ELIM),
                  .BLINK_HALF_MS(BH)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pa_present(pa_strap),
        .fault_strobe(flt), .emerg_req(emg), .fpga_rst_n(fpga_rst_n),
        .pa_vdd_en(pa_vdd_en), .tx_mix_en(tx_mix_en), .safe_led(safe_led)
    );

    // Behavioural reference: 0 hold, 1 ramp, 2 run with PA, 3 safe, 4 run RX only
    int m_st = 0, m_tc = 0, m_ec = 0, m_bc = 0, m_en = 0;
    bit m_em = 0, m_ld = 1, m_trip = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tc = 0; m_ec = 0; m_em = 0; m_bc = 0; m_ld = 1;
        end else begin
            m_en = m_ec + ((flt && m_ec < ELIM + 1) ? 1 : 0);
            m_trip = m_em || emg || (m_en > ELIM);
            m_ec = m_en;
            if (m_trip) begin
                m_em = 1;
                if (m_st != 3) begin
                    m_st = 3; m_bc = 0; m_ld = 1;
                end else if (ms_tick) begin
                    if (m_bc == BH - 1) begin m_bc = 0; m_ld = !m_ld; end
                    else m_bc++;
                end
            end else if (m_st == 0 && ms_tick) begin
                if (m_tc == RST_MS - 1) begin m_tc = 0; m_st = pa_strap ? 1 : 4; end
                else m_tc++;
            end else if (m_st == 1 && ms_tick) begin
                if (m_tc == SETTLE - 1) begin m_tc = 0; m_st = 2; end
                else m_tc++;
            end
        end
    end

    task automatic chk(string req, string nm, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s [%s] actual=%b expected=%b t=%0t", req, nm, phase, act, exp, $time);
        end
    endtask

    // Compare every output each cycle at the falling edge, then drive the tick
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R2", "fpga_rst_n", fpga_rst_n, logic'(m_st != 0));
            chk("R3", "pa_vdd_en", pa_vdd_en, logic'(m_st == 1 || m_st == 2));
            chk("R5", "tx_mix_en", tx_mix_en, logic'(m_st == 2 || m_st == 4));
            chk("R9", "safe_led", safe_led, logic'(m_st == 3 && m_ld));
            cyc++;
            ms_tick = ((cyc % TICKDIV) == 0);
        end
    endtask

    task automatic do_reset(logic strap);
        rst_n = 1'b0; pa_strap = strap; flt = 1'b0; emg = 1'b0;
        phase = "R1 reset";
        step(3);
        // R1: all outputs low while in reset
        chk("R1", "fpga_rst_n@rst", fpga_rst_n, 1'b0);
        chk("R1", "pa_vdd_en@rst", pa_vdd_en, 1'b0);
        chk("R1", "tx_mix_en@rst", tx_mix_en, 1'b0);
        chk("R1", "safe_led@rst", safe_led, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        // Scenario: full bring-up with the amplifier path (R2, R3, R5)
        do_reset(1'b1);
        phase = "R2 R3 R5 bring-up with PA";
        step(110);
        chk("R5", "mixer on after settle", tx_mix_en, 1'b1);

        // Scenario: direct emergency, then blinking and saturation (R6, R9, R8)
        phase = "R6 emergency request";
        emg = 1'b1; step(1); emg = 1'b0;
        chk("R6", "pa off after request", pa_vdd_en, 1'b0);
        phase = "R9 blink";
        step(60);
        phase = "R8 sticky under faults";
        flt = 1'b1; step(30); flt = 1'b0;
        emg = 1'b1; step(2); emg = 1'b0;
        step(20);
        chk("R8", "still out of reset in safe", fpga_rst_n, 1'b1);

        // Scenario: no amplifier path (R4)
        do_reset(1'b0);
        phase = "R4 rx-only bring-up";
        step(80);
        chk("R4", "pa never on", pa_vdd_en, 1'b0);

        // Scenario: count-driven trip while running (R7)
        phase = "R7 fault count trip";
        for (int k = 0; k < ELIM + 1; k++) begin
            flt = 1'b1; step(1); flt = 1'b0; step(5);
        end
        chk("R7", "mixer off after count trip", tx_mix_en, 1'b0);
        step(30);

        // Scenario: trip during the reset hold, then a clean restart (R10)
        do_reset(1'b1);
        phase = "R10 trip in hold";
        step(8);
        flt = 1'b1; step(ELIM + 1); flt = 1'b0;
        step(90);
        chk("R10", "pa never rose", pa_vdd_en, 1'b0);
        do_reset(1'b1);
        phase = "R10 restart";
        step(110);
        chk("R10", "restart reaches run", tx_mix_en, 1'b1);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule